// File: doc/BRIEF.md
# Split-Tag Direct-Mapped Translation Cache

This block caches virtual-to-physical page translations in a direct-mapped array and keeps a separate tag array for each access kind: instruction fetch, load and store. One physical page number array is shared by all three. A lookup is combinational: the access kind selects which tag array must hold the full virtual page number at the indexed slot, and on a hit the physical address is the stored page number joined with the untranslated 12-bit offset.

On a miss the block works out the effective privilege of the access. When that privilege is machine mode (or translation is switched off entirely) it completes the fill itself with an identity mapping. Otherwise it raises a refill request towards an external page walker and holds it until the walker answers. Each completed fill is checked against the size of physical memory; a page at or beyond that limit, or a walker failure, yields an access fault of the matching kind instead of a tag write. A flush input empties all three tag arrays and drops any pending refill.

Top module: `xlt_split_cache`

## Requirements
- R1: The slot index is the virtual page number (`req_vaddr_i[VA_W-1:12]`) modulo ENTRIES; a hit needs the stored tag to equal the whole virtual page number, and `paddr_o` is then the stored physical page number concatenated with `req_vaddr_i[11:0]`.
- R2: Access kind codes are 0 = fetch, 1 = load, 2 = store (3 is treated as load); a fill made for one kind gives hits for that kind only, never for the other two.
- R3: A successful fill clears every tag at the filled slot that differs from the new page number and writes the new page number into the filling kind's tag only.
- R4: A flush pulse marks every tag in all three arrays invalid (all ones) and abandons a pending refill without any completion or fault pulse.
- R5: Privilege codes are user = 0, supervisor = 1, machine = 3; data accesses use `priv_prev_i` when `mprv_i` is 1, fetches always use `priv_cur_i`.
- R6: With `bare_i` high or effective privilege machine, a miss completes without a refill request, mapping the physical page to the virtual page number, and `done_o` or `fault_o` pulses in the next cycle.
- R7: Otherwise a miss raises `walk_req_o` in the next cycle with the page number, kind and `walk_super_o` (effective privilege above user), all held stable until a response.
- R8: A physical page number at or above MEM_PAGES causes a one-cycle `fault_o` with `fault_kind_o` equal to the access kind, and no tag is written.
- R9: A walker response with `walk_rsp_fail_i` high causes a `fault_o` of the access kind and writes no tag.
- R10: After reset all tags are invalid, nothing hits, and no refill is requested.
- R11: While a refill is outstanding `req_ready_o` is low and no hit is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate all tags, drop pending refill |
| req_valid_i | input | 1 | Lookup request present |
| req_kind_i | input | 2 | Access kind (0 fetch, 1 load, 2 store) |
| req_vaddr_i | input | VA_W | Virtual address |
| priv_cur_i | input | 2 | Current privilege |
| priv_prev_i | input | 2 | Previous privilege, used by data accesses when mprv_i is set |
| mprv_i | input | 1 | Data accesses take previous privilege |
| bare_i | input | 1 | Translation switched off |
| req_ready_o | output | 1 | No refill outstanding |
| hit_o | output | 1 | Lookup hit for the request's kind |
| paddr_o | output | PA_W | Physical address on hit |
| walk_req_o | output | 1 | Refill request to the walker |
| walk_vpn_o | output | VA_W-12 | Page number to translate |
| walk_kind_o | output | 2 | Access kind of the refill |
| walk_super_o | output | 1 | Effective privilege above user |
| walk_rsp_valid_i | input | 1 | Walker response |
| walk_rsp_ppn_i | input | PA_W-12 | Physical page number from the walker |
| walk_rsp_fail_i | input | 1 | Walker found no valid mapping |
| done_o | output | 1 | Fill written (one-cycle pulse) |
| fault_o | output | 1 | Access fault (one-cycle pulse) |
| fault_kind_o | output | 2 | Kind of the faulting access |

## Verification
Every cycle the assertions watch the refill handshake (request held steady, flush abandoning it), that a bypassed miss never reaches the walker, that a failed walk turns into a fault of the right kind, that every hit points inside physical memory, and that a fill or flush leaves the tag arrays as intended. Which privilege source is chosen, the split between the three kinds, eviction of the other kinds' tags at a shared slot and the page-offset concatenation only show in the bench's scenarios, where later probes of other kinds and page numbers reveal them.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_LOAD  = 2'd1;
  localparam logic [1:0] KIND_STORE = 2'd2;

  localparam logic [1:0] PRIV_USER  = 2'd0;
  localparam logic [1:0] PRIV_MACH  = 2'd3;

  // Kind 3 has no tag array of its own; it behaves as a load.
  function automatic logic [1:0] norm_kind(input logic [1:0] k);
    return (k == 2'd3) ? KIND_LOAD : k;
  endfunction

  // Effective privilege: data may borrow the previous level, bare forces machine.
  function automatic logic [1:0] eff_priv(input logic [1:0] kind,
                                          input logic [1:0] cur,
                                          input logic [1:0] prev,
                                          input logic mprv,
                                          input logic bare);
    logic [1:0] p;
    p = (kind != KIND_FETCH && mprv) ? prev : cur;
    if (bare) p = PRIV_MACH;
    return p;
  endfunction

  function automatic logic page_below(input logic [63:0] ppn, input logic [63:0] lim);
    return ppn < lim;
  endfunction
endpackage

// File: rtl/xlt_mode_sel.sv
module xlt_mode_sel
  import xlt_pkg::*;
(
  input  logic [1:0] kind_i,
  input  logic [1:0] priv_cur_i,
  input  logic [1:0] priv_prev_i,
  input  logic       mprv_i,
  input  logic       bare_i,
  output logic       bypass_o,
  output logic       super_o
);
  logic [1:0] eff;

  always_comb begin
    eff      = eff_priv(kind_i, priv_cur_i, priv_prev_i, mprv_i, bare_i);
    bypass_o = (eff == PRIV_MACH);
    super_o  = (eff != PRIV_USER);
  end
endmodule

// File: rtl/xlt_tag_bank.sv
module xlt_tag_bank #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int KIND    = 0,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic [IDX_W-1:0] look_idx_i,
  input  logic [VPN_W-1:0] look_vpn_i,
  output logic             match_o,
  input  logic             upd_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic [VPN_W-1:0] upd_vpn_i,
  input  logic [1:0]       upd_kind_i
);
  localparam logic [VPN_W-1:0] INVALID = '1;

  logic [VPN_W-1:0] tag_q [ENTRIES];
  logic             own;

  assign own     = (upd_kind_i == KIND[1:0]);
  assign match_o = (tag_q[look_idx_i] == look_vpn_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tag_q[i] <= INVALID;
    end else if (flush_i) begin
      for (int i = 0; i < ENTRIES; i++) tag_q[i] <= INVALID;
    end else if (upd_i) begin
      if (own) tag_q[upd_idx_i] <= upd_vpn_i;
      else if (tag_q[upd_idx_i] != upd_vpn_i) tag_q[upd_idx_i] <= INVALID;
    end
  end

  // R3: the filling kind's tag holds the new page number afterwards
  a_r3_own_tag_written: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i && own && !flush_i |=> tag_q[$past(upd_idx_i)] == $past(upd_vpn_i));

  // R3: other kinds end up either equal to the new page or invalid
  a_r3_other_tag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i && !own && !flush_i |=>
      (tag_q[$past(upd_idx_i)] == $past(upd_vpn_i)) || (tag_q[$past(upd_idx_i)] == INVALID));

  // R4: flush leaves first and last slot invalid
  a_r4_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> tag_q[0] == INVALID && tag_q[ENTRIES-1] == INVALID);
endmodule

// File: rtl/xlt_split_cache.sv
module xlt_split_cache
  import xlt_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int MEM_PAGES = 256,
  localparam int OFF_W    = 12,
  localparam int VPN_W    = VA_W - OFF_W,
  localparam int PPN_W    = PA_W - OFF_W,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             req_valid_i,
  input  logic [1:0]       req_kind_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [1:0]       priv_cur_i,
  input  logic [1:0]       priv_prev_i,
  input  logic             mprv_i,
  input  logic             bare_i,
  output logic             req_ready_o,
  output logic             hit_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic             walk_req_o,
  output logic [VPN_W-1:0] walk_vpn_o,
  output logic [1:0]       walk_kind_o,
  output logic             walk_super_o,
  input  logic             walk_rsp_valid_i,
  input  logic [PPN_W-1:0] walk_rsp_ppn_i,
  input  logic             walk_rsp_fail_i,
  output logic             done_o,
  output logic             fault_o,
  output logic [1:0]       fault_kind_o
);
  logic             busy_q;
  logic [VPN_W-1:0] pend_vpn_q;
  logic [1:0]       pend_kind_q;
  logic             pend_super_q;
  logic [PPN_W-1:0] ppn_q [ENTRIES];
  logic             done_q, fault_q;
  logic [1:0]       fault_kind_q;

  logic [VPN_W-1:0] req_vpn;
  logic [IDX_W-1:0] req_idx;
  logic [1:0]       req_kind;
  logic [2:0]       kind_match;
  logic             sel_match;
  logic             bypass, super_lvl;

  // named internal events
  logic             miss_start, bypass_fin, walk_start, rsp_take;
  logic             fin_evt, fin_fail, fin_in_range, fill_ok, fault_evt;
  logic [VPN_W-1:0] fin_vpn;
  logic [1:0]       fin_kind;
  logic [PPN_W-1:0] fin_ppn;

  assign req_vpn  = req_vaddr_i[VA_W-1:OFF_W];
  assign req_idx  = req_vpn[IDX_W-1:0];
  assign req_kind = norm_kind(req_kind_i);

  xlt_mode_sel u_mode (
    .kind_i     (req_kind),
    .priv_cur_i (priv_cur_i),
    .priv_prev_i(priv_prev_i),
    .mprv_i     (mprv_i),
    .bare_i     (bare_i),
    .bypass_o   (bypass),
    .super_o    (super_lvl)
  );

  for (genvar k = 0; k < 3; k++) begin : g_bank
    xlt_tag_bank #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .KIND(k)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush_i   (flush_i),
      .look_idx_i(req_idx),
      .look_vpn_i(req_vpn),
      .match_o   (kind_match[k]),
      .upd_i     (fill_ok),
      .upd_idx_i (fin_vpn[IDX_W-1:0]),
      .upd_vpn_i (fin_vpn),
      .upd_kind_i(fin_kind)
    );
  end

  always_comb begin
    sel_match    = kind_match[req_kind];
    hit_o        = req_valid_i && !busy_q && sel_match;
    paddr_o      = {ppn_q[req_idx], req_vaddr_i[OFF_W-1:0]};
    miss_start   = req_valid_i && !busy_q && !sel_match && !flush_i;
    bypass_fin   = miss_start && bypass;
    walk_start   = miss_start && !bypass;
    rsp_take     = busy_q && walk_rsp_valid_i && !flush_i;
    fin_evt      = bypass_fin || rsp_take;
    fin_vpn      = busy_q ? pend_vpn_q  : req_vpn;
    fin_kind     = busy_q ? pend_kind_q : req_kind;
    fin_ppn      = busy_q ? walk_rsp_ppn_i : PPN_W'(req_vpn);
    fin_fail     = busy_q && walk_rsp_fail_i;
    fin_in_range = page_below(64'(fin_ppn), 64'(MEM_PAGES));
    fill_ok      = fin_evt && !fin_fail && fin_in_range;
    fault_evt    = fin_evt && !fill_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      pend_vpn_q   <= '0;
      pend_kind_q  <= KIND_FETCH;
      pend_super_q <= 1'b0;
      done_q       <= 1'b0;
      fault_q      <= 1'b0;
      fault_kind_q <= KIND_FETCH;
    end else begin
      done_q  <= fill_ok;
      fault_q <= fault_evt;
      if (fault_evt) fault_kind_q <= fin_kind;
      if (flush_i) busy_q <= 1'b0;
      else if (walk_start) begin
        busy_q       <= 1'b1;
        pend_vpn_q   <= req_vpn;
        pend_kind_q  <= req_kind;
        pend_super_q <= super_lvl;
      end else if (rsp_take) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_ok) ppn_q[fin_vpn[IDX_W-1:0]] <= fin_ppn;
  end

  assign req_ready_o  = !busy_q;
  assign walk_req_o   = busy_q;
  assign walk_vpn_o   = pend_vpn_q;
  assign walk_kind_o  = pend_kind_q;
  assign walk_super_o = pend_super_q;
  assign done_o       = done_q;
  assign fault_o      = fault_q;
  assign fault_kind_o = fault_kind_q;

  // R6: a bypassed miss finishes next cycle without touching the walker
  a_r6_bypass_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_fin |=> !walk_req_o && (done_o || fault_o));

  // R7: request fields hold until the walker answers
  a_r7_walk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_o && !walk_rsp_valid_i && !flush_i |=>
      walk_req_o && $stable(walk_vpn_o) && $stable(walk_kind_o) && $stable(walk_super_o));

  // R9: a failed walk becomes a fault of the pending kind
  a_r9_fail_faults: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_o && walk_rsp_valid_i && walk_rsp_fail_i && !flush_i |=>
      fault_o && !done_o && fault_kind_o == $past(walk_kind_o));

  // R8: every hit lands inside physical memory
  a_r8_hit_in_memory: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> 64'(paddr_o[PA_W-1:OFF_W]) < 64'(MEM_PAGES));

  // R4: flush drops a pending refill silently
  a_r4_flush_abort: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !walk_req_o && !done_o && !fault_o);

  // R11: busy blocks hits
  a_r11_busy_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_o |-> !hit_o && !req_ready_o);
endmodule

// File: tb/test_xlt_split_cache.sv
`timescale 1ns/100ps
module test_xlt_split_cache;
  localparam int ENTRIES = 8, VA_W = 32, PA_W = 32, MEM_PAGES = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 0, req_valid = 0, mprv = 0, bare = 0;
  logic [1:0] req_kind = 0, pcur = 3, pprev = 0;
  logic [31:0] vaddr = 0;
  logic ready, hit, wreq, wsuper, done, fault;
  logic [31:0] paddr;
  logic [19:0] wvpn;
  logic [1:0] wkind, fkind;
  logic rsp_valid = 0, rsp_fail = 0;
  logic [19:0] rsp_ppn = 0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  xlt_split_cache #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .MEM_PAGES(MEM_PAGES)) i_xlt_split_cache (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .req_vaddr_i(vaddr), .priv_cur_i(pcur), .priv_prev_i(pprev), .mprv_i(mprv), .bare_i(bare),
    .req_ready_o(ready), .hit_o(hit), .paddr_o(paddr), .walk_req_o(wreq), .walk_vpn_o(wvpn),
    .walk_kind_o(wkind), .walk_super_o(wsuper), .walk_rsp_valid_i(rsp_valid),
    .walk_rsp_ppn_i(rsp_ppn), .walk_rsp_fail_i(rsp_fail), .done_o(done), .fault_o(fault),
    .fault_kind_o(fkind));

  typedef struct packed {
    logic [1:0] kind; logic [1:0] cur; logic [1:0] prev; logic mp; logic br;
    logic [19:0] vpn; logic [19:0] rppn; logic rfail;
    logic ewalk; logic esuper; logic efault; logic [19:0] eppn;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 2'd3, 2'd0, 1'b0, 1'b0, 20'h00011, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0, 20'h011}, // R6 machine fetch
    '{2'd1, 2'd1, 2'd0, 1'b0, 1'b1, 20'h00022, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0, 20'h022}, // R6 bare
    '{2'd1, 2'd3, 2'd0, 1'b1, 1'b0, 20'h12343, 20'h33, 1'b0, 1'b1, 1'b0, 1'b0, 20'h033}, // R5 data uses prev=U
    '{2'd0, 2'd0, 2'd3, 1'b1, 1'b0, 20'h00054, 20'h44, 1'b0, 1'b1, 1'b0, 1'b0, 20'h044}, // R5 fetch ignores mprv
    '{2'd2, 2'd1, 2'd0, 1'b0, 1'b0, 20'h00065, 20'h10, 1'b1, 1'b1, 1'b1, 1'b1, 20'h0},   // R9 walker fail
    '{2'd2, 2'd3, 2'd0, 1'b0, 1'b0, 20'h00405, 20'h0, 1'b0, 1'b0, 1'b0, 1'b1, 20'h0},    // R8 bypass out of range
    '{2'd1, 2'd1, 2'd0, 1'b0, 1'b0, 20'h00076, 20'h100, 1'b0, 1'b1, 1'b1, 1'b1, 20'h0},  // R8 walked out of range
    '{2'd1, 2'd0, 2'd3, 1'b1, 1'b0, 20'h00087, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0, 20'h087}   // R5 data uses prev=M
  };

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Combinational probe that never reaches a clock edge with req_valid high.
  task automatic probe(input logic [1:0] k, input logic [19:0] vpn, input logic [11:0] off,
                       output logic h, output logic [31:0] pa);
    @(negedge clk);
    req_kind = k; vaddr = {vpn, off}; pcur = 2'd3; mprv = 0; bare = 0; req_valid = 1;
    #0.5 h = hit; pa = paddr;
    req_valid = 0;
  endtask

  task automatic access(input logic [1:0] k, input logic [1:0] cur, input logic [1:0] prv,
                        input logic mp, input logic br, input logic [19:0] vpn);
    @(negedge clk);
    req_kind = k; pcur = cur; pprev = prv; mprv = mp; bare = br; vaddr = {vpn, 12'h0};
    req_valid = 1;
    @(posedge clk); #0.5 req_valid = 0;
  endtask

  initial begin : watchdog
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic h; logic [31:0] pa;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R10 reset state
    chk(ready, 1, "R10 ready after reset");
    chk(wreq, 0, "R10 no walk after reset");
    for (int k = 0; k < 3; k++) begin
      probe(k[1:0], 20'h00011, 12'h0, h, pa);
      chk(h, 0, "R10 no hit after reset");
    end

    foreach (VEC[i]) begin
      access(VEC[i].kind, VEC[i].cur, VEC[i].prev, VEC[i].mp, VEC[i].br, VEC[i].vpn);
      @(negedge clk);
      chk(wreq, VEC[i].ewalk, $sformatf("R6/R7 walk request vec %0d", i));
      if (VEC[i].ewalk) begin
        chk(wvpn, VEC[i].vpn, "R7 walk vpn");
        chk(wkind, VEC[i].kind, "R7 walk kind");
        chk(wsuper, VEC[i].esuper, "R5 supervisor flag");
        chk(ready, 0, "R11 busy not ready");
        req_kind = VEC[i].kind; vaddr = {VEC[i].vpn, 12'h0}; req_valid = 1;
        #0.5 chk(hit, 0, "R11 no hit while busy");
        req_valid = 0;
        @(negedge clk);
        chk({wreq, wvpn}, {1'b1, VEC[i].vpn}, "R7 held stable");
        rsp_valid = 1; rsp_ppn = VEC[i].rppn; rsp_fail = VEC[i].rfail;
        @(posedge clk); #0.5 rsp_valid = 0; rsp_fail = 0;
        @(negedge clk);
      end
      chk(done, !VEC[i].efault, $sformatf("R8/R9 done vec %0d", i));
      chk(fault, VEC[i].efault, $sformatf("R8/R9 fault vec %0d", i));
      if (VEC[i].efault) chk(fkind, VEC[i].kind, "R8/R9 fault kind");
      probe(VEC[i].kind, VEC[i].vpn, 12'hABC, h, pa);
      chk(h, !VEC[i].efault, $sformatf("R1 own kind hit vec %0d", i));
      if (!VEC[i].efault) chk(pa, {VEC[i].eppn, 12'hABC}, "R1 physical address");
      for (int k = 0; k < 3; k++) begin
        if (k[1:0] != VEC[i].kind) begin
          probe(k[1:0], VEC[i].vpn, 12'h0, h, pa);
          chk(h, 0, "R2 other kind misses");
        end
      end
    end

    // R3 shared slot: store fill on same page keeps load tag, new page evicts all
    access(2'd2, 2'd3, 2'd0, 0, 0, 20'h00022);
    probe(2'd1, 20'h00022, 12'h0, h, pa); chk(h, 1, "R3 load kept on same page");
    probe(2'd2, 20'h00022, 12'h0, h, pa); chk(h, 1, "R3 store written");
    access(2'd1, 2'd3, 2'd0, 0, 0, 20'h0002A);
    probe(2'd2, 20'h00022, 12'h0, h, pa); chk(h, 0, "R3 store evicted");
    probe(2'd1, 20'h00022, 12'h0, h, pa); chk(h, 0, "R3 old load replaced");
    probe(2'd1, 20'h0002A, 12'h5, h, pa); chk(pa, {20'h0002A, 12'h5}, "R3 new load address");
    chk(h, 1, "R3 new load hit");

    // R4 flush clears everything and aborts a pending walk
    @(negedge clk) flush = 1;
    @(negedge clk) flush = 0;
    probe(2'd1, 20'h0002A, 12'h0, h, pa); chk(h, 0, "R4 load gone after flush");
    probe(2'd0, 20'h00011, 12'h0, h, pa); chk(h, 0, "R4 fetch gone after flush");
    access(2'd1, 2'd1, 2'd0, 0, 0, 20'h00031);
    @(negedge clk); chk(wreq, 1, "R7 walk started");
    flush = 1;
    @(negedge clk); flush = 0;
    chk(wreq, 0, "R4 walk dropped");
    chk(ready, 1, "R4 ready after flush");
    rsp_valid = 1; rsp_ppn = 20'h31;
    @(negedge clk); rsp_valid = 0;
    chk({done, fault}, 2'b00, "R4 stale response ignored");
    probe(2'd1, 20'h00031, 12'h0, h, pa); chk(h, 0, "R4 no fill from stale response");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule